// File: doc/BRIEF.md
# Multicycle Accumulator Processor Core

This block is a small stored-program processor built around a single 16-bit accumulator. Every instruction is brought in from memory through an address register and a buffer register, placed in an instruction register, decoded, and then carried out as a short, fixed sequence of register transfers. A state machine sequences these transfers. The datapath holds a 12-bit program counter, a 12-bit memory address register, a 16-bit memory buffer register, a 16-bit instruction register, the accumulator, an 8-bit input register and an 8-bit output register.

The core drives a word-addressed synchronous memory. The address and write data come straight from the address and buffer registers. Read data is returned one clock after the address is presented. An external device loads the input register by pulsing a load strobe. Each Output instruction presents a byte on the output port together with a one-cycle valid pulse. After a Halt instruction the core stops issuing memory cycles and raises a sticky halted flag.

Top module: `acc_cpu_core`

## Requirements
- R1: While reset is low, and in the cycle after it is released, `halted`, `out_valid`, `mem_we`, `out_data` and `mem_addr` are all zero. The first instruction is fetched from address 0.
- R2: An instruction word holds its opcode in bits 15:12 and its address field in bits 11:0. Opcode 0x1 (Load) copies the memory word at the address field into the accumulator.
- R3: Opcode 0x2 (Store) writes the accumulator to the memory word at the address field. `mem_we` is high for exactly one cycle, and it is high at no other time.
- R4: Opcode 0x3 (Add) adds the memory word at the address field to the accumulator. Opcode 0x4 (Subt) subtracts that word from the accumulator. Both results wrap modulo 2^16 in two's complement.
- R5: The input register captures `in_data` on every clock where `in_load` is high and holds its value otherwise. Opcode 0x5 (Input) loads the accumulator with the input register sign-extended to 16 bits.
- R6: Opcode 0x6 (Output) places accumulator bits 7:0 on `out_data` and raises `out_valid` for exactly one cycle. `out_data` holds that byte until the next Output.
- R7: Opcode 0x7 (Halt) sets `halted`, which then stays high until reset. While halted, no memory write and no output pulse occur, and `mem_addr` does not change.
- R8: Opcode 0x8 (Skipcond) tests the accumulator using address bits 11:10. The code 00 skips when the accumulator is negative, 01 skips when it is zero, 10 skips when it is positive, and 11 never skips. A skip advances the program counter by one extra word.
- R9: Opcode 0x9 (Jump) loads the program counter with the address field, so the next fetch comes from that address.
- R10: Opcodes 0x0 and 0xA to 0xF change no architectural state: no write, no output, and no accumulator change.
- R11: Each fetch advances the program counter by one, and the count wraps from 0xFFF to 0x000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| mem_addr | output | 12 | Word address presented to the memory |
| mem_wdata | output | 16 | Word to be written to memory |
| mem_we | output | 1 | Memory write enable |
| mem_rdata | input | 16 | Word read from memory, valid one clock after the address |
| in_data | input | 8 | Byte from the input device |
| in_load | input | 1 | Strobe that loads `in_data` into the input register |
| out_data | output | 8 | Byte held in the output register |
| out_valid | output | 1 | One-cycle strobe after each Output instruction |
| halted | output | 1 | High once a Halt instruction has executed |

## Verification
Arithmetic is driven with operands that cross the signed overflow boundary (0x7FFF + 2, then a subtraction that goes below zero). This separates a true 16-bit wrap from a saturating or sign-truncating adder. The conditional skip is tried with all four condition codes against a negative, a zero and a positive accumulator. That grid catches any swapped condition bit, a comparison that is unsigned where it should be signed, or a code 11 that skips when it should not. Input is driven with bytes whose top bit is set and with bytes whose top bit is clear, which tells sign extension apart from zero extension. A further run changes `in_data` without the load strobe to show that the input register holds its value. Jump, the unused opcodes and a program that runs across the top address each show, through stores and output bytes, which path the program counter took.

// File: rtl/acc_cpu_pkg.sv
package acc_cpu_pkg;

  localparam int OPC_W = 4;

  localparam logic [OPC_W-1:0] OP_LOAD   = 4'h1;
  localparam logic [OPC_W-1:0] OP_STORE  = 4'h2;
  localparam logic [OPC_W-1:0] OP_ADD    = 4'h3;
  localparam logic [OPC_W-1:0] OP_SUBT   = 4'h4;
  localparam logic [OPC_W-1:0] OP_INPUT  = 4'h5;
  localparam logic [OPC_W-1:0] OP_OUTPUT = 4'h6;
  localparam logic [OPC_W-1:0] OP_HALT   = 4'h7;
  localparam logic [OPC_W-1:0] OP_SKIP   = 4'h8;
  localparam logic [OPC_W-1:0] OP_JUMP   = 4'h9;

  // Micro-step sequencer states
  typedef enum logic [3:0] {
    ST_F_MAR,  // MAR <- PC
    ST_F_RD,   // memory access in flight
    ST_F_MBR,  // MBR <- memory
    ST_F_IR,   // IR <- MBR, PC <- PC+1
    ST_DEC,    // decode
    ST_X_MAR,  // MAR <- address field
    ST_X_RD,   // operand read in flight
    ST_X_MBR,  // MBR <- memory or AC
    ST_X_FIN,  // AC update or memory write
    ST_X_ONE,  // single-step operations
    ST_HALT
  } cpu_state_e;

  // Accumulator source select
  typedef enum logic [2:0] {
    AC_HOLD,
    AC_MBR,
    AC_ADD,
    AC_SUB,
    AC_IN
  } ac_sel_e;

endpackage

// File: rtl/acc_cpu_ctrl.sv
module acc_cpu_ctrl
  import acc_cpu_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OPC_W-1:0] opcode,
  output logic             mar_from_pc,
  output logic             mar_from_ir,
  output logic             mbr_from_mem,
  output logic             mbr_from_ac,
  output logic             ir_load,
  output ac_sel_e          ac_sel,
  output logic             mem_we,
  output logic             out_evt,
  output logic             jump_evt,
  output logic             skip_evt,
  output logic             halted
);

  cpu_state_e state, nxt;

  logic is_store;
  logic is_memop;

  assign is_store = (opcode == OP_STORE);
  assign is_memop = (opcode == OP_LOAD) || (opcode == OP_STORE) ||
                    (opcode == OP_ADD)  || (opcode == OP_SUBT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_F_MAR;
    else        state <= nxt;
  end

  always_comb begin
    nxt = state;
    unique case (state)
      ST_F_MAR: nxt = ST_F_RD;
      ST_F_RD:  nxt = ST_F_MBR;
      ST_F_MBR: nxt = ST_F_IR;
      ST_F_IR:  nxt = ST_DEC;
      ST_DEC: begin
        if (is_memop)                nxt = ST_X_MAR;
        else if (opcode == OP_HALT)  nxt = ST_HALT;
        else                         nxt = ST_X_ONE;
      end
      ST_X_MAR: nxt = is_store ? ST_X_MBR : ST_X_RD;
      ST_X_RD:  nxt = ST_X_MBR;
      ST_X_MBR: nxt = ST_X_FIN;
      ST_X_FIN: nxt = ST_F_MAR;
      ST_X_ONE: nxt = ST_F_MAR;
      ST_HALT:  nxt = ST_HALT;
      default:  nxt = ST_F_MAR;
    endcase
  end

  // Named micro-step strobes
  assign mar_from_pc  = (state == ST_F_MAR);
  assign mar_from_ir  = (state == ST_X_MAR);
  assign mbr_from_mem = (state == ST_F_MBR) || ((state == ST_X_MBR) && !is_store);
  assign mbr_from_ac  = (state == ST_X_MBR) && is_store;
  assign ir_load      = (state == ST_F_IR);
  assign mem_we       = (state == ST_X_FIN) && is_store;
  assign out_evt      = (state == ST_X_ONE) && (opcode == OP_OUTPUT);
  assign jump_evt     = (state == ST_X_ONE) && (opcode == OP_JUMP);
  assign skip_evt     = (state == ST_X_ONE) && (opcode == OP_SKIP);
  assign halted       = (state == ST_HALT);

  always_comb begin
    ac_sel = AC_HOLD;
    if (state == ST_X_FIN) begin
      if (opcode == OP_LOAD)      ac_sel = AC_MBR;
      else if (opcode == OP_ADD)  ac_sel = AC_ADD;
      else if (opcode == OP_SUBT) ac_sel = AC_SUB;
    end else if ((state == ST_X_ONE) && (opcode == OP_INPUT)) begin
      ac_sel = AC_IN;
    end
  end

  // R3: a write lasts a single cycle
  a_r3_we_single: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> !mem_we);

  // R7: halted is sticky
  a_r7_halt_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    halted |=> halted);

  // R7: nothing leaves the core once halted
  a_r7_halt_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    halted |-> (!mem_we && !out_evt && !ir_load));

  // R11: every fetch is followed by a decode, then never a second IR load at once
  a_r11_fetch_once: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> !ir_load);

endmodule

// File: rtl/acc_cpu_dpath.sv
module acc_cpu_dpath
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mar_from_pc,
  input  logic              mar_from_ir,
  input  logic              mbr_from_mem,
  input  logic              mbr_from_ac,
  input  logic              ir_load,
  input  ac_sel_e           ac_sel,
  input  logic              out_evt,
  input  logic              jump_evt,
  input  logic              skip_evt,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [IO_W-1:0]   in_data,
  input  logic              in_load,
  output logic [OPC_W-1:0]  opcode,
  output logic [ADDR_W-1:0] mar_q,
  output logic [DATA_W-1:0] mbr_q,
  output logic [IO_W-1:0]   out_data,
  output logic              out_valid
);

  localparam logic [ADDR_W-1:0] PC_STEP = ADDR_W'(1);
  localparam int                EXT_W   = DATA_W - IO_W;

  logic [ADDR_W-1:0] pc;
  logic [DATA_W-1:0] ir;
  logic [DATA_W-1:0] ac;
  logic [IO_W-1:0]   in_reg;
  logic              skip_take;

  function automatic logic [DATA_W-1:0] widen_in(input logic [IO_W-1:0] b);
    return {{EXT_W{b[IO_W-1]}}, b};
  endfunction

  function automatic logic cond_met(input logic [1:0] code,
                                    input logic [DATA_W-1:0] a);
    logic neg, zer;
    neg = a[DATA_W-1];
    zer = (a == '0);
    case (code)
      2'b00:   return neg;
      2'b01:   return zer;
      2'b10:   return !neg && !zer;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [DATA_W-1:0] ac_next(input ac_sel_e sel,
                                                input logic [DATA_W-1:0] a,
                                                input logic [DATA_W-1:0] m,
                                                input logic [IO_W-1:0] i);
    case (sel)
      AC_MBR:  return m;
      AC_ADD:  return a + m;
      AC_SUB:  return a - m;
      AC_IN:   return widen_in(i);
      default: return a;
    endcase
  endfunction

  assign opcode    = ir[DATA_W-1 -: OPC_W];
  assign skip_take = skip_evt && cond_met(ir[ADDR_W-1 -: 2], ac);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pc        <= '0;
      mar_q     <= '0;
      mbr_q     <= '0;
      ir        <= '0;
      ac        <= '0;
      in_reg    <= '0;
      out_data  <= '0;
      out_valid <= 1'b0;
    end else begin
      if (mar_from_pc)       mar_q <= pc;
      else if (mar_from_ir)  mar_q <= ir[ADDR_W-1:0];

      if (mbr_from_mem)      mbr_q <= mem_rdata;
      else if (mbr_from_ac)  mbr_q <= ac;

      if (ir_load)           ir <= mbr_q;

      if (ir_load || skip_take) pc <= pc + PC_STEP;
      else if (jump_evt)        pc <= ir[ADDR_W-1:0];

      ac <= ac_next(ac_sel, ac, mbr_q, in_reg);

      if (in_load) in_reg <= in_data;

      out_valid <= out_evt;
      if (out_evt) out_data <= ac[IO_W-1:0];
    end
  end

  // R11: fetch advances PC by one with wrap
  a_r11_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
    ir_load |=> (pc == $past(pc) + PC_STEP));

  // R9: jump lands on the address field
  a_r9_jump_target: assert property (@(posedge clk) disable iff (!rst_n)
    jump_evt |=> (pc == $past(ir[ADDR_W-1:0])));

  // R8: an untaken skip leaves PC alone
  a_r8_no_skip_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_evt && !skip_take) |=> $stable(pc));

  // R8: code 11 never skips
  a_r8_code3_never: assert property (@(posedge clk) disable iff (!rst_n)
    (skip_evt && (ir[ADDR_W-1 -: 2] == 2'b11)) |-> !skip_take);

  // R6: output strobe is a single pulse
  a_r6_valid_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);

  // R6: output byte holds between Output instructions
  a_r6_byte_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !out_evt |=> $stable(out_data));

endmodule

// File: rtl/acc_cpu_core.sv
module acc_cpu_core
  import acc_cpu_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 16,
  parameter int IO_W   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic [DATA_W-1:0] mem_rdata,
  input  logic [IO_W-1:0]   in_data,
  input  logic              in_load,
  output logic [IO_W-1:0]   out_data,
  output logic              out_valid,
  output logic              halted
);

  logic             mar_from_pc, mar_from_ir, mbr_from_mem, mbr_from_ac;
  logic             ir_load, out_evt, jump_evt, skip_evt;
  ac_sel_e          ac_sel;
  logic [OPC_W-1:0] opcode;

  acc_cpu_ctrl u_ctrl (
    .clk          (clk),
    .rst_n        (rst_n),
    .opcode       (opcode),
    .mar_from_pc  (mar_from_pc),
    .mar_from_ir  (mar_from_ir),
    .mbr_from_mem (mbr_from_mem),
    .mbr_from_ac  (mbr_from_ac),
    .ir_load      (ir_load),
    .ac_sel       (ac_sel),
    .mem_we       (mem_we),
    .out_evt      (out_evt),
    .jump_evt     (jump_evt),
    .skip_evt     (skip_evt),
    .halted       (halted)
  );

  acc_cpu_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .IO_W   (IO_W)
  ) u_dpath (
    .clk          (clk),
    .rst_n        (rst_n),
    .mar_from_pc  (mar_from_pc),
    .mar_from_ir  (mar_from_ir),
    .mbr_from_mem (mbr_from_mem),
    .mbr_from_ac  (mbr_from_ac),
    .ir_load      (ir_load),
    .ac_sel       (ac_sel),
    .out_evt      (out_evt),
    .jump_evt     (jump_evt),
    .skip_evt     (skip_evt),
    .mem_rdata    (mem_rdata),
    .in_data      (in_data),
    .in_load      (in_load),
    .opcode       (opcode),
    .mar_q        (mem_addr),
    .mbr_q        (mem_wdata),
    .out_data     (out_data),
    .out_valid    (out_valid)
  );

  // R7: address frozen while halted
  a_r7_addr_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (halted && $past(halted)) |-> $stable(mem_addr));

endmodule

// File: tb/acc_cpu_core_tb.sv
module acc_cpu_core_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] mem_addr;
  logic [15:0] mem_wdata;
  logic        mem_we;
  logic [15:0] mem_rdata;
  logic [7:0]  in_data = 8'h00;
  logic        in_load = 1'b0;
  logic [7:0]  out_data;
  logic        out_valid;
  logic        halted;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  acc_cpu_core u_dut (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_we(mem_we), .mem_rdata(mem_rdata), .in_data(in_data),
    .in_load(in_load), .out_data(out_data), .out_valid(out_valid),
    .halted(halted)
  );

  // Memory model with a loader path
  logic [15:0] mem [4096];
  logic        ld_en = 1'b0;
  logic [11:0] ld_a  = '0;
  logic [15:0] ld_d  = '0;

  always @(posedge clk) begin
    if (ld_en)       mem[ld_a] <= ld_d;
    else if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  int       we_cnt;
  int       out_cnt;
  logic [7:0] out_last;
  always @(posedge clk) begin
    if (!rst_n) begin
      we_cnt <= 0; out_cnt <= 0; out_last <= 8'h00;
    end else begin
      if (mem_we) we_cnt <= we_cnt + 1;
      if (out_valid) begin out_cnt <= out_cnt + 1; out_last <= out_data; end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic put(input logic [11:0] a, input logic [15:0] d);
    @(negedge clk); ld_en = 1'b1; ld_a = a; ld_d = d;
    @(negedge clk); ld_en = 1'b0;
  endtask

  // Enter reset and check the reset state (R1)
  task automatic hold_reset();
    @(negedge clk); rst_n = 1'b0; in_load = 1'b0;
    @(negedge clk);
    check("R1 halted", halted, 0);
    check("R1 out_valid", out_valid, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 mem_addr", mem_addr, 0);
    check("R1 out_data", out_data, 0);
  endtask

  task automatic go(input logic do_load, input logic [7:0] b);
    @(negedge clk); rst_n = 1'b1; in_load = do_load; in_data = b;
    @(negedge clk); in_load = 1'b0; in_data = 8'h11;
  endtask

  task automatic wait_halt(input string req);
    int n = 0;
    while (!halted && n < 3000) begin @(negedge clk); n++; end
    check(req, halted, 1);
  endtask

  // R2 R3 R4 R7: arithmetic, stores and halt
  task automatic t_arith();
    hold_reset();
    put(12'h000, 16'h1100); put(12'h001, 16'h3101); put(12'h002, 16'h2102);
    put(12'h003, 16'h4103); put(12'h004, 16'h2104); put(12'h005, 16'h7000);
    put(12'h100, 16'h7FFF); put(12'h101, 16'h0002); put(12'h102, 16'h0BAD);
    put(12'h103, 16'h8002); put(12'h104, 16'h0BAD);
    go(1'b0, 8'h00);
    wait_halt("R7 halt reached");
    check("R2 R4 add wrap", mem[12'h102], 16'h8001);
    check("R4 subt wrap", mem[12'h104], 16'hFFFF);
    check("R3 write count", we_cnt, 2);
    begin
      logic [11:0] a0 = mem_addr;
      int w0 = we_cnt;
      repeat (40) begin
        @(negedge clk);
        if (out_valid) check("R7 no output", out_valid, 0);
      end
      check("R7 halted sticky", halted, 1);
      check("R7 no write", we_cnt, w0);
      check("R7 addr frozen", mem_addr, a0);
    end
  endtask

  // R5 R6: input sign extension, hold, output strobe
  task automatic t_io(input logic [7:0] v, input logic [15:0] exp);
    hold_reset();
    put(12'h000, 16'h5000); put(12'h001, 16'h2100);
    put(12'h002, 16'h6000); put(12'h003, 16'h7000);
    put(12'h100, 16'h0BAD);
    go(1'b1, v);
    wait_halt("R5 run");
    check("R5 input extend and hold", mem[12'h100], exp);
    check("R6 out pulses", out_cnt, 1);
    check("R6 out byte", out_last, v);
    check("R6 out_data held", out_data, v);
  endtask

  // R8: skip condition grid
  task automatic t_skip(input logic [1:0] code, input logic [15:0] v);
    logic neg, zer, take;
    neg = v[15]; zer = (v == 16'h0);
    take = (code == 2'b00 && neg) || (code == 2'b01 && zer) ||
           (code == 2'b10 && !neg && !zer);
    hold_reset();
    put(12'h000, 16'h1100); put(12'h001, {4'h8, code, 10'h000});
    put(12'h002, 16'h6000); put(12'h003, 16'h7000);
    put(12'h100, v);
    go(1'b0, 8'h00);
    wait_halt("R8 run");
    check($sformatf("R8 code %0d ac %0h", code, v), out_cnt, take ? 0 : 1);
  endtask

  // R9: jump
  task automatic t_jump();
    hold_reset();
    put(12'h000, 16'h9200); put(12'h001, 16'h6000); put(12'h002, 16'h6000);
    put(12'h200, 16'h1100); put(12'h201, 16'h6000); put(12'h202, 16'h7000);
    put(12'h100, 16'h125A);
    go(1'b0, 8'h00);
    wait_halt("R9 run");
    check("R9 jump out count", out_cnt, 1);
    check("R9 jump out byte", out_last, 8'h5A);
  endtask

  // R10: unused opcodes
  task automatic t_nop();
    hold_reset();
    put(12'h000, 16'h1100);
    put(12'h001, 16'h0123);
    for (int k = 10; k < 16; k++) put(12'(k - 8), {4'(k), 12'h123});
    put(12'h008, 16'h6000); put(12'h009, 16'h7000);
    put(12'h100, 16'h0042); put(12'h123, 16'h0BEE);
    go(1'b0, 8'h00);
    wait_halt("R10 run");
    check("R10 ac unchanged", out_last, 8'h42);
    check("R10 no writes", we_cnt, 0);
    check("R10 target untouched", mem[12'h123], 16'h0BEE);
  endtask

  // R11: PC wrap
  task automatic t_wrap();
    hold_reset();
    put(12'h000, 16'h8800); put(12'h001, 16'h9FFF);
    put(12'h002, 16'h2100); put(12'h003, 16'h7000);
    put(12'hFFF, 16'h5000); put(12'h100, 16'hDEAD);
    go(1'b1, 8'h05);
    wait_halt("R11 run");
    check("R11 pc wrap path", mem[12'h100], 16'h0005);
  endtask

  initial begin
    t_arith();
    t_io(8'h9C, 16'hFF9C);
    t_io(8'h3A, 16'h003A);
    for (int c = 0; c < 4; c++) begin
      t_skip(2'(c), 16'h8000);
      t_skip(2'(c), 16'h0000);
      t_skip(2'(c), 16'h0005);
    end
    t_jump();
    t_nop();
    t_wrap();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(4 * 150000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule